// File: doc/BRIEF.md
# Frame Pulse Aligner

This block produces one top-of-frame pulse per video frame. It counts reference-clock cycles into lines and lines into frames, and both counts come from configuration inputs. When no frame reference arrives, the pulse repeats at the configured frame period without end.

A vertical sync input, and for interlaced timing also a field input, can supply an external frame reference. Each reference edge is synchronised and compared with the position of the internal counter. A two-bit policy then chooses one of three actions: ignore the reference, snap the counter to it on every event, or snap only when the two disagree.

A status output shows whether the most recent reference landed outside the tolerance window. A force-free-run control makes the block ignore every sync input.

Top module: `frame_pulse_aligner`

## Requirements
- R1: While `rst_n` is low, `frame_pulse` and `frame_misaligned` are both 0.
- R2: In free run, `frame_pulse` repeats every `cfg_line_clks * cfg_frame_lines` clock cycles and is high for exactly one cycle.
- R3: `vsync_in` and `field_in` pass through a two-flop synchroniser. With `sync_pol_rise` = 0, a falling edge of `vsync_in` is the active edge. With `sync_pol_rise` = 1, a rising edge is the active edge. When the counter is realigned, `frame_pulse` rises 3 clock cycles after the input edge is applied.
- R4: When `interlaced` = 0, every active vertical edge is a frame reference. When `interlaced` = 1, an active vertical edge counts only while `field_in` is low.
- R5: `align_mode` 2'b11 (the default policy) and 2'b01 (reserved) never move the counter.
- R6: `align_mode` 2'b10 realigns the counter on every frame reference, including one that is already within the window.
- R7: `align_mode` 2'b00 realigns only when a reference falls outside the window. The window is the counter's last two positions of the frame plus its start position, which means the reference is within one clock of the expected frame start.
- R8: On each frame reference, `frame_misaligned` becomes 1 if the reference was outside the window and 0 if it was inside.
- R9: While `free_run_force` = 1, all sync inputs are ignored, the counter is never moved, and `frame_misaligned` reads 0.
- R10: If no frame reference occurs for two configured frame periods, `frame_misaligned` returns to 0 and the pulse keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_line_clks | input | CW | Clock cycles per line |
| cfg_frame_lines | input | LW | Lines per frame |
| vsync_in | input | 1 | Vertical sync, asynchronous |
| field_in | input | 1 | Field identifier, asynchronous |
| sync_pol_rise | input | 1 | 1 selects the rising edge as active |
| align_mode | input | 2 | Realignment policy |
| free_run_force | input | 1 | Ignore all sync inputs |
| interlaced | input | 1 | Frame reference needs field low |
| frame_pulse | output | 1 | One-cycle top-of-frame pulse |
| frame_misaligned | output | 1 | Last reference was outside the window |

## Verification
Each stimulus places one active vertical edge a chosen number of cycles after a frame pulse. The bench then measures the gap until the next pulse: a gap of the full period means the counter was left alone, and a shortened gap means it was realigned. The offsets are chosen to straddle the tolerance window (27, 28 and 29 cycles in a 32-cycle frame), so the stay-or-snap decision of each policy is exposed at its edge. Further patterns repeat the same offset with the field input high or low, with forced free run and with each edge polarity. These tell apart an ignored edge from an edge that counts as a reference.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

  typedef enum logic [1:0] {
    ALN_AUTO   = 2'b00,
    ALN_RSV    = 2'b01,
    ALN_ALWAYS = 2'b10,
    ALN_NEVER  = 2'b11
  } aln_mode_e;

  // True when the counter position is within one clock of the frame start:
  // the last two positions of the frame, or the start position itself.
  function automatic logic near_frame_start(input int unsigned pix,
                                            input int unsigned line,
                                            input int unsigned cpl,
                                            input int unsigned lpf);
    logic at_start;
    logic at_tail;
    at_start = (pix == 0) && (line == 0);
    at_tail  = (line == lpf - 1) && ((pix == cpl - 1) || (pix == cpl - 2));
    return at_start || at_tail;
  endfunction

  // Cycles without a reference after which the reference counts as absent.
  function automatic int unsigned absence_limit(input int unsigned cpl,
                                                input int unsigned lpf);
    return 2 * cpl * lpf;
  endfunction

endpackage

// File: rtl/fpa_sync.sv
module fpa_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q;
    logic stab_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= din[i];
        stab_q <= meta_q;
      end
    end
    assign lvl[i] = stab_q;
  end

endmodule

// File: rtl/fpa_timebase.sv
module fpa_timebase #(
  parameter int CW = 12,
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cpl_i,
  input  logic [LW-1:0] lpf_i,
  input  logic          realign_i,
  output logic [CW-1:0] pix_o,
  output logic [LW-1:0] line_o,
  output logic          pulse_o
);

  logic          run_q;
  logic [CW-1:0] pix_q;
  logic [LW-1:0] line_q;
  logic          line_end;
  logic          frame_end;

  assign line_end  = (pix_q >= cpl_i - CW'(1));
  assign frame_end = (line_q >= lpf_i - LW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pix_q  <= '0;
      line_q <= '0;
    end else begin
      run_q <= 1'b1;
      if (realign_i) begin
        pix_q  <= '0;
        line_q <= '0;
      end else if (run_q) begin
        if (line_end) begin
          pix_q  <= '0;
          line_q <= frame_end ? '0 : line_q + LW'(1);
        end else begin
          pix_q <= pix_q + CW'(1);
        end
      end
    end
  end

  assign pix_o   = pix_q;
  assign line_o  = line_q;
  assign pulse_o = run_q && (pix_q == '0) && (line_q == '0);

  AST_REALIGN_TO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (realign_i && run_q) |=> pulse_o) else $error("realign did not restart frame"); // R6
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_o && !realign_i && (cpl_i > CW'(1)) && $stable(cpl_i)) |=> !pulse_o)
    else $error("frame pulse wider than one cycle"); // R2

endmodule

// File: rtl/fpa_align_ctl.sv
module fpa_align_ctl
  import fpa_pkg::*;
#(
  parameter int CW = 12,
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vs_lvl_i,
  input  logic          fld_lvl_i,
  input  logic          pol_rise_i,
  input  logic          interlaced_i,
  input  logic          force_i,
  input  logic [1:0]    mode_i,
  input  logic [CW-1:0] pix_i,
  input  logic [LW-1:0] line_i,
  input  logic [CW-1:0] cpl_i,
  input  logic [LW-1:0] lpf_i,
  output logic          realign_o,
  output logic          misaligned_o
);

  localparam int TW = CW + LW + 1;

  aln_mode_e     mode;
  logic          vs_prev_q;
  logic          vs_edge;
  logic          ref_evt;
  logic          near;
  logic [TW-1:0] gap_cnt_q;
  logic [TW-1:0] limit;
  logic          absent;
  logic          mis_q;

  assign mode    = aln_mode_e'(mode_i);
  assign vs_edge = pol_rise_i ? (vs_lvl_i && !vs_prev_q) : (!vs_lvl_i && vs_prev_q);
  assign ref_evt = !force_i && vs_edge && (!interlaced_i || !fld_lvl_i);
  assign near    = near_frame_start(32'(pix_i), 32'(line_i), 32'(cpl_i), 32'(lpf_i));
  assign limit   = TW'(absence_limit(32'(cpl_i), 32'(lpf_i)));
  assign absent  = (gap_cnt_q >= limit);

  always_comb begin
    unique case (mode)
      ALN_ALWAYS: realign_o = ref_evt;
      ALN_AUTO:   realign_o = ref_evt && !near;
      default:    realign_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vs_prev_q <= 1'b0;
      gap_cnt_q <= '0;
      mis_q     <= 1'b0;
    end else begin
      vs_prev_q <= vs_lvl_i;
      if (ref_evt)      gap_cnt_q <= '0;
      else if (!absent) gap_cnt_q <= gap_cnt_q + TW'(1);
      if (force_i)      mis_q <= 1'b0;
      else if (ref_evt) mis_q <= !near;
      else if (absent)  mis_q <= 1'b0;
    end
  end

  assign misaligned_o = mis_q;

  AST_FORCE_BLOCKS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    force_i |-> !realign_o) else $error("realign under forced free run"); // R9
  AST_FORCE_CLEARS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    force_i |=> !misaligned_o) else $error("status set under forced free run"); // R9
  AST_NEVER_POLICY: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == ALN_NEVER) || (mode == ALN_RSV)) |-> !realign_o)
    else $error("counter moved under never policy"); // R5
  AST_ALWAYS_POLICY: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == ALN_ALWAYS) && ref_evt) |-> realign_o)
    else $error("reference skipped under always policy"); // R6
  AST_AUTO_ONLY_MISALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == ALN_AUTO) && realign_o) |=> misaligned_o)
    else $error("auto policy moved an aligned counter"); // R7
  AST_ABSENT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (absent && !ref_evt) |=> !misaligned_o) else $error("status kept without reference"); // R10

endmodule

// File: rtl/frame_pulse_aligner.sv
module frame_pulse_aligner #(
  parameter int CW = 12,
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_line_clks,
  input  logic [LW-1:0] cfg_frame_lines,
  input  logic          vsync_in,
  input  logic          field_in,
  input  logic          sync_pol_rise,
  input  logic [1:0]    align_mode,
  input  logic          free_run_force,
  input  logic          interlaced,
  output logic          frame_pulse,
  output logic          frame_misaligned
);

  logic [1:0]    sync_lvl;
  logic [CW-1:0] pix;
  logic [LW-1:0] line;
  logic          realign;

  fpa_sync #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({field_in, vsync_in}),
    .lvl   (sync_lvl)
  );

  fpa_align_ctl #(.CW(CW), .LW(LW)) u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .vs_lvl_i     (sync_lvl[0]),
    .fld_lvl_i    (sync_lvl[1]),
    .pol_rise_i   (sync_pol_rise),
    .interlaced_i (interlaced),
    .force_i      (free_run_force),
    .mode_i       (align_mode),
    .pix_i        (pix),
    .line_i       (line),
    .cpl_i        (cfg_line_clks),
    .lpf_i        (cfg_frame_lines),
    .realign_o    (realign),
    .misaligned_o (frame_misaligned)
  );

  fpa_timebase #(.CW(CW), .LW(LW)) u_tb (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpl_i     (cfg_line_clks),
    .lpf_i     (cfg_frame_lines),
    .realign_i (realign),
    .pix_o     (pix),
    .line_o    (line),
    .pulse_o   (frame_pulse)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!frame_pulse && !frame_misaligned)) else $error("outputs active in reset"); // R1

endmodule

// File: tb/frame_pulse_aligner_bench.sv
module frame_pulse_aligner_bench;

  localparam int CLK_P = 10;
  localparam int CW = 12;
  localparam int LW = 11;

  typedef struct packed {
    logic [1:0] mode;
    logic       intl;
    logic       fld;
    logic       pol;
    logic       ffr;
    logic [7:0] d;
    logic [7:0] gap;
    logic [1:0] mis;   // 2 = not checked
  } vec_t;

  // 8 clocks/line, 4 lines/frame: period 32, window = positions 30,31,0
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'd10, 8'd32, 2'd1},  // R5 never
    '{2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 8'd10, 8'd13, 2'd1},  // R6 always, R3 latency
    '{2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'd10, 8'd13, 2'd1},  // R7 auto, misaligned
    '{2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'd29, 8'd32, 2'd0},  // R7 exactly aligned
    '{2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'd28, 8'd32, 2'd0},  // R7 one clock early
    '{2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'd27, 8'd30, 2'd1},  // R7 two clocks early
    '{2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 8'd28, 8'd31, 2'd0},  // R6 realign inside window
    '{2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 8'd10, 8'd32, 2'd1},  // R5 reserved, R8
    '{2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 8'd10, 8'd13, 2'd1},  // R4 interlaced field low
    '{2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 8'd10, 8'd32, 2'd2},  // R4 interlaced field high
    '{2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 8'd10, 8'd32, 2'd0},  // R9 forced free run
    '{2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 8'd5,  8'd8,  2'd1},  // R3 rising polarity
    '{2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 8'd20, 8'd23, 2'd1}   // R3 back to falling, R8
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] cfg_line_clks = CW'(8);
  logic [LW-1:0] cfg_frame_lines = LW'(4);
  logic          vsync_in = 1'b1;
  logic          field_in = 1'b0;
  logic          sync_pol_rise = 1'b0;
  logic [1:0]    align_mode = 2'b11;
  logic          free_run_force = 1'b0;
  logic          interlaced = 1'b0;
  logic          frame_pulse;
  logic          frame_misaligned;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  frame_pulse_aligner #(.CW(CW), .LW(LW)) u_frame_pulse_aligner (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_line_clks    (cfg_line_clks),
    .cfg_frame_lines  (cfg_frame_lines),
    .vsync_in         (vsync_in),
    .field_in         (field_in),
    .sync_pol_rise    (sync_pol_rise),
    .align_mode       (align_mode),
    .free_run_force   (free_run_force),
    .interlaced       (interlaced),
    .frame_pulse      (frame_pulse),
    .frame_misaligned (frame_misaligned)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse();
    int g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!frame_pulse && g < 200);
  endtask

  task automatic pulse_gap(output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!frame_pulse && k < 200);
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int k;
    string tag;
    vsync_in = sync_pol_rise ? 1'b0 : 1'b1;
    repeat (4) @(negedge clk);
    sync_pol_rise  = v.pol;
    align_mode     = v.mode;
    interlaced     = v.intl;
    field_in       = v.fld;
    free_run_force = v.ffr;
    vsync_in       = v.pol ? 1'b0 : 1'b1;
    repeat (4) @(negedge clk);
    wait_pulse();
    repeat (int'(v.d)) @(negedge clk);
    vsync_in = v.pol ? 1'b1 : 1'b0;
    k = int'(v.d);
    do begin
      @(negedge clk);
      k++;
    end while (!frame_pulse && k < 200);
    tag = $sformatf("vector %0d gap", idx);
    chk(tag, k, int'(v.gap));
    if (v.mis != 2'd2) begin
      tag = $sformatf("vector %0d status (R8)", idx);
      chk(tag, int'(frame_misaligned), int'(v.mis));
    end
  endtask

  initial begin
    int g;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 pulse in reset", int'(frame_pulse), 0);
    chk("R1 status in reset", int'(frame_misaligned), 0);
    rst_n = 1'b1;

    // R2: free-run period and width
    wait_pulse();
    g = 0;
    @(negedge clk);
    g++;
    chk("R2 pulse width", int'(frame_pulse), 0);
    while (!frame_pulse && g < 200) begin
      @(negedge clk);
      g++;
    end
    chk("R2 period 8x4", g, 32);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R10: status decays without a reference
    run_vec('{2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'd10, 8'd32, 2'd1}, NV);
    repeat (20) @(negedge clk);
    chk("R10 status still held", int'(frame_misaligned), 1);
    repeat (40) @(negedge clk);
    chk("R10 status cleared after absence", int'(frame_misaligned), 0);
    wait_pulse();
    pulse_gap(g);
    chk("R10 pulse keeps running", g, 32);

    // R2: another geometry
    cfg_line_clks   = CW'(5);
    cfg_frame_lines = LW'(3);
    wait_pulse();
    wait_pulse();
    pulse_gap(g);
    chk("R2 period 5x3", g, 15);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule